// File: doc/BRIEF.md
# Data Cache Line Flush Unit

This unit carries out a single-line flush against a small direct-mapped write-back data cache. The issue stage hands it an instruction word and the values of its two register operands. If the word carries the flush encoding and the unit is idle, the unit takes the request. It forms the effective address and reads the tag and state entry of the selected line. The translation flags sampled with the request decide whether an access fault ends the operation before anything else happens.

When the line holds the address and is modified, the unit streams the whole line to memory one word per beat, lowest word first, through a ready/valid write port. It then clears the line's valid and modified state. A clean hit only clears the line. A miss completes quietly with no memory traffic and no change to the cache. The cacheability attribute of the address has no influence on any of this. No register result is produced.

For debug address matching, every accepted flush is reported as a store access on a one-cycle pulse. For access-fault purposes it is classed as a load, so a no-access zone blocks it in user mode.

Top module: `dline_flush_unit`

## Requirements
- R1: The effective address is `rb_val` plus a base. The base is zero when the A-register field `req_instr[20:16]` is zero, and `ra_val` otherwise. The address appears on `dbg_ea` while `dbg_valid` is high.
- R2: A request is taken when `req_valid` is high and the unit is idle, with `req_instr[31:26]`=31 and `req_instr[10:1]`=86. Values in the reserved bits `req_instr[25:21]` and `req_instr[0]` do not prevent acceptance. Any other encoding is ignored and `busy` stays low.
- R3: On a hit to a modified line (tag equal to `ea[31:11]`, index `ea[10:5]`), the unit issues 8 write beats. Beat k has address line base + 4k and data equal to word k of the line, and `mw_last` is high on beat 7. Each beat holds until `mw_ready` is high. `arr_inv` pulses in the cycle after the last beat is accepted.
- R4: On a hit to an unmodified line, `arr_inv` pulses for one cycle with no write beat.
- R5: `attr_inhibit` has no effect: a modified hit is written back with it high.
- R6: On a miss (line invalid or tag different) there is no write beat and no `arr_inv`. `done` pulses with no fault.
- R7: When `reloc_en` is high and `tlb_hit` is low, `fault_dtlb` pulses with `done` and the line is neither written nor invalidated. This fault takes priority over the zone fault.
- R8: When `mode_user`, `reloc_en`, `zone_no_access` and `tlb_hit` are all high, `fault_dstor` pulses with `done` and no flush occurs. In supervisor mode the zone flag has no effect.
- R9: In the cycle after acceptance, `dbg_valid` pulses for one cycle with `dbg_kind` = 2'b10 (store). `dbg_kind` is 2'b00 otherwise.
- R10: `busy` is high from the cycle after acceptance through the cycle in which `done` is high. Requests presented while `busy` is high are ignored.
- R11: `done` is a single-cycle pulse, once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from issue |
| req_instr | input | 32 | Instruction word |
| ra_val | input | 32 | Value of the A register |
| rb_val | input | 32 | Value of the B register |
| mode_user | input | 1 | Problem-state (user) mode |
| reloc_en | input | 1 | Data relocation enabled |
| zone_no_access | input | 1 | Protection zone forbids the access |
| tlb_hit | input | 1 | A valid translation exists |
| attr_inhibit | input | 1 | Cacheability-inhibited attribute (ignored) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| fault_dtlb | output | 1 | Data translation-miss fault pulse |
| fault_dstor | output | 1 | Data storage fault pulse |
| dbg_valid | output | 1 | Debug address-compare report pulse |
| dbg_ea | output | 32 | Effective address for debug compare |
| dbg_kind | output | 2 | Access kind, 2'b10 = store |
| arr_idx | output | 6 | Line index into the cache arrays |
| arr_word | output | 3 | Word select within the line |
| arr_tag_q | input | 21 | Tag of the indexed line |
| arr_valid_q | input | 1 | Valid bit of the indexed line |
| arr_dirty_q | input | 1 | Modified bit of the indexed line |
| arr_rdata | input | 32 | Selected data word |
| arr_inv | output | 1 | Clear valid and modified at `arr_idx` |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory accepts the beat |
| mw_addr | output | 32 | Beat byte address |
| mw_data | output | 32 | Beat data |
| mw_last | output | 1 | Final beat of the line |

## Verification
The bench stalls the write port at random points. A design that advanced its beat counter without `mw_ready`, or dropped a beat, would leave memory with missing or shifted words. A design that invalidated too early would clear the line before the last word left. Separate runs drive a miss on a modified line with a different tag, a translation miss, a user-mode zone fault and a supervisor-mode zone request. A unit that skipped the tag compare or ignored a fault would corrupt memory there, and a unit that applied zone protection in supervisor mode would leave the line valid. Further runs cover a zero A-field with a non-zero `ra_val`, reserved bits set, a wrong extended opcode, and a second request held during write-back. A design that dropped the base rule, rejected reserved bits or accepted while busy would report a wrong address or flush the wrong line.

// File: rtl/dflush_pkg.sv
package dflush_pkg;

   localparam logic [5:0] FLUSH_PRIMARY_OP = 6'd31;
   localparam logic [9:0] FLUSH_EXT_OP     = 10'd86;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_LOOK  = 2'd1,
      FS_WBACK = 2'd2,
      FS_INVAL = 2'd3
   } flush_state_e;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'b00,
      ACC_LOAD  = 2'b01,
      ACC_STORE = 2'b10
   } acc_kind_e;

   typedef struct packed {
      logic user;
      logic reloc;
      logic zone_na;
      logic xlat_ok;
   } xlat_flags_t;

endpackage

// File: rtl/dflush_decode_ea.sv
module dflush_decode_ea
   import dflush_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [5:0]        op_field,
   input  logic [9:0]        xo_field,
   input  logic [4:0]        ra_field,
   input  logic [ADDR_W-1:0] ra_val,
   input  logic [ADDR_W-1:0] rb_val,
   output logic              is_flush,
   output logic [ADDR_W-1:0] ea
);

   logic              ra_is_zero;
   logic [ADDR_W-1:0] base;

   assign is_flush   = (op_field == FLUSH_PRIMARY_OP) && (xo_field == FLUSH_EXT_OP);
   assign ra_is_zero = (ra_field == 5'd0);
   assign base       = ra_is_zero ? '0 : ra_val;
   assign ea         = base + rb_val;

endmodule

// File: rtl/dflush_fault_chk.sv
module dflush_fault_chk
   import dflush_pkg::*;
#(
   parameter bit TLB_FIRST = 1'b1
) (
   input  xlat_flags_t fl,
   output logic        f_tlb,
   output logic        f_dstor
);

   logic tlb_raw;
   logic dst_raw;

   assign tlb_raw = fl.reloc & ~fl.xlat_ok;
   assign dst_raw = fl.user & fl.reloc & fl.zone_na;

   generate
      if (TLB_FIRST) begin : g_tlb_first
         assign f_tlb   = tlb_raw;
         assign f_dstor = dst_raw & ~tlb_raw;
      end else begin : g_zone_first
         assign f_dstor = dst_raw;
         assign f_tlb   = tlb_raw & ~dst_raw;
      end
   endgenerate

endmodule

// File: rtl/dflush_tag_match.sv
module dflush_tag_match #(
   parameter int TAG_W = 21
) (
   input  logic [TAG_W-1:0] req_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  logic             line_valid,
   input  logic             line_dirty,
   output logic             hit,
   output logic             hit_dirty
);

   assign hit       = line_valid && (line_tag == req_tag);
   assign hit_dirty = hit && line_dirty;

endmodule

// File: rtl/dflush_seq.sv
module dflush_seq
   import dflush_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WPL    = 8,
   localparam int BEAT_W = (WPL > 1) ? $clog2(WPL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] ea_in,
   input  xlat_flags_t       flags_in,
   input  logic              look_hit,
   input  logic              look_dirty,
   input  logic              look_fault,
   input  logic              wr_ready,
   output flush_state_e      state,
   output logic [BEAT_W-1:0] beat,
   output logic              last_beat,
   output logic [ADDR_W-1:0] ea_q,
   output xlat_flags_t       flags_q
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WPL - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= FS_IDLE;
         ea_q    <= '0;
         flags_q <= '0;
      end else begin
         case (state)
            FS_IDLE: begin
               if (start) begin
                  state   <= FS_LOOK;
                  ea_q    <= ea_in;
                  flags_q <= flags_in;
               end
            end
            FS_LOOK: begin
               if (look_fault || !look_hit) state <= FS_IDLE;
               else if (look_dirty)         state <= FS_WBACK;
               else                         state <= FS_INVAL;
            end
            FS_WBACK: begin
               if (wr_ready && last_beat) state <= FS_INVAL;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   generate
      if (WPL > 1) begin : g_beat_cnt
         always_ff @(posedge clk) begin
            if (!rst_n)                          beat <= '0;
            else if (state == FS_LOOK)           beat <= '0;
            else if (state == FS_WBACK && wr_ready) beat <= beat + 1'b1;
         end
         assign last_beat = (beat == LAST_BEAT);
      end else begin : g_single_word
         assign beat      = '0;
         assign last_beat = 1'b1;
      end
   endgenerate

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_WBACK && !wr_ready) |=> (state == FS_WBACK && $stable(beat)))
      else $error("beat advanced without ready");

   assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != FS_IDLE) |=> (state == FS_IDLE || $stable(ea_q)))
      else $error("latched address changed while busy");

endmodule

// File: rtl/dline_flush_unit.sv
module dline_flush_unit
   import dflush_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 64,
   parameter int LINE_BYTES = 32,
   parameter bit TLB_FIRST  = 1'b1,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int WPL    = LINE_BYTES / (DATA_W / 8),
   localparam int BEAT_W = (WPL > 1) ? $clog2(WPL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_instr,
   input  logic [ADDR_W-1:0] ra_val,
   input  logic [ADDR_W-1:0] rb_val,
   input  logic              mode_user,
   input  logic              reloc_en,
   input  logic              zone_no_access,
   input  logic              tlb_hit,
   input  logic              attr_inhibit,
   output logic              busy,
   output logic              done,
   output logic              fault_dtlb,
   output logic              fault_dstor,
   output logic              dbg_valid,
   output logic [ADDR_W-1:0] dbg_ea,
   output logic [1:0]        dbg_kind,
   output logic [IDX_W-1:0]  arr_idx,
   output logic [BEAT_W-1:0] arr_word,
   input  logic [TAG_W-1:0]  arr_tag_q,
   input  logic              arr_valid_q,
   input  logic              arr_dirty_q,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              arr_inv,
   output logic              mw_valid,
   input  logic              mw_ready,
   output logic [ADDR_W-1:0] mw_addr,
   output logic [DATA_W-1:0] mw_data,
   output logic              mw_last
);

   localparam int WB_W = $clog2(DATA_W / 8);

   initial begin
      assert (DATA_W % 8 == 0 && (DATA_W / 8) == (1 << WB_W))
         else $error("word width must be a power-of-two byte count");
      assert (LINE_BYTES == (1 << OFF_W) && LINE_BYTES >= DATA_W / 8)
         else $error("line size must be a power of two of at least one word");
      assert (LINES == (1 << IDX_W) && TAG_W > 0)
         else $error("line count must be a power of two leaving tag bits");
   end

   logic              is_flush;
   logic [ADDR_W-1:0] ea_new;
   logic              start;
   xlat_flags_t       flags_in;
   flush_state_e      state;
   logic [BEAT_W-1:0] beat;
   logic              last_beat;
   logic [ADDR_W-1:0] ea_q;
   xlat_flags_t       flags_q;
   logic              f_tlb, f_dstor, f_any;
   logic              hit, hit_dirty;
   logic              in_look;
   logic [ADDR_W-1:0] line_base;
   logic              rsvd_nz;

   dflush_decode_ea #(.ADDR_W(ADDR_W)) u_decode (
      .op_field (req_instr[31:26]),
      .xo_field (req_instr[10:1]),
      .ra_field (req_instr[20:16]),
      .ra_val   (ra_val),
      .rb_val   (rb_val),
      .is_flush (is_flush),
      .ea       (ea_new)
   );

   assign busy     = (state != FS_IDLE);
   assign start    = req_valid && is_flush && !busy;
   assign flags_in = '{user: mode_user, reloc: reloc_en, zone_na: zone_no_access, xlat_ok: tlb_hit};
   assign rsvd_nz  = |{req_instr[25:21], req_instr[0]};

   dflush_seq #(.ADDR_W(ADDR_W), .WPL(WPL)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ea_in      (ea_new),
      .flags_in   (flags_in),
      .look_hit   (hit),
      .look_dirty (hit_dirty),
      .look_fault (f_any),
      .wr_ready   (mw_ready),
      .state      (state),
      .beat       (beat),
      .last_beat  (last_beat),
      .ea_q       (ea_q),
      .flags_q    (flags_q)
   );

   dflush_fault_chk #(.TLB_FIRST(TLB_FIRST)) u_fault (
      .fl      (flags_q),
      .f_tlb   (f_tlb),
      .f_dstor (f_dstor)
   );
   assign f_any = f_tlb | f_dstor;

   assign arr_idx  = ea_q[OFF_W +: IDX_W];
   assign arr_word = beat;

   dflush_tag_match #(.TAG_W(TAG_W)) u_tag (
      .req_tag    (ea_q[ADDR_W-1 -: TAG_W]),
      .line_tag   (arr_tag_q),
      .line_valid (arr_valid_q),
      .line_dirty (arr_dirty_q),
      .hit        (hit),
      .hit_dirty  (hit_dirty)
   );

   assign in_look     = (state == FS_LOOK);
   assign done        = (in_look && (f_any || !hit)) || (state == FS_INVAL);
   assign fault_dtlb  = in_look && f_tlb;
   assign fault_dstor = in_look && f_dstor;
   assign dbg_valid   = in_look;
   assign dbg_ea      = ea_q;
   assign dbg_kind    = in_look ? ACC_STORE : ACC_NONE;

   assign line_base = {ea_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mw_valid  = (state == FS_WBACK);
   assign mw_addr   = line_base + (ADDR_W'(beat) << WB_W);
   assign mw_data   = arr_rdata;
   assign mw_last   = mw_valid && last_beat;
   assign arr_inv   = (state == FS_INVAL);

   assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_flush && !busy && rsvd_nz) |=> busy)
      else $error("reserved bits blocked acceptance");

   assert_inv_after_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && mw_ready && mw_last) |=> (arr_inv && done))
      else $error("no invalidate after last beat");

   assert_wb_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)))
      else $error("write beat dropped under stall");

   assert_inhibit_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_look && hit_dirty && !f_any && attr_inhibit) |=> mw_valid)
      else $error("inhibited attribute suppressed write-back");

   assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_valid && done && !fault_dtlb && !fault_dstor) |=> (!busy && !mw_valid && !arr_inv))
      else $error("miss produced activity");

   assert_fault_no_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_dtlb || fault_dstor) |=> (!busy && !mw_valid && !arr_inv))
      else $error("flush proceeded after fault");

   assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_dtlb, fault_dstor}))
      else $error("both faults raised");

   assert_dbg_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> dbg_valid)
      else $error("no debug report after acceptance");

   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy)
      else $error("busy dropped before done");

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

endmodule

// File: tb/tb_dline_flush_unit.sv
`timescale 1ns/1ps
module tb_dline_flush_unit;

   localparam int WD_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_instr = '0;
   logic [31:0] ra_val = '0, rb_val = '0;
   logic        mode_user = 1'b0, reloc_en = 1'b0, zone_no_access = 1'b0;
   logic        tlb_hit = 1'b1, attr_inhibit = 1'b0;
   logic        busy, done, fault_dtlb, fault_dstor, dbg_valid;
   logic [31:0] dbg_ea;
   logic [1:0]  dbg_kind;
   logic [5:0]  arr_idx;
   logic [2:0]  arr_word;
   logic [20:0] arr_tag_q;
   logic        arr_valid_q, arr_dirty_q;
   logic [31:0] arr_rdata;
   logic        arr_inv, mw_valid, mw_last;
   logic        mw_ready = 1'b1;
   logic [31:0] mw_addr, mw_data;

   always #2 clk = ~clk;

   dline_flush_unit dut (.*);

   // behavioural cache arrays
   logic [20:0] c_tag [64];
   logic        c_val [64];
   logic        c_dty [64];
   logic [31:0] c_dat [64][8];

   assign arr_tag_q   = c_tag[arr_idx];
   assign arr_valid_q = c_val[arr_idx];
   assign arr_dirty_q = c_dty[arr_idx];
   assign arr_rdata   = c_dat[arr_idx][arr_word];

   int errors = 0, checks = 0, cyc = 0;
   logic [63:0] wq[$];
   int  n_done = 0;
   bit  saw_tlb = 0, saw_dst = 0, saw_store = 0, saw_busy = 0;
   bit  rdy_rand = 0;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   int          ms = 0, mbeat = 0;
   logic [31:0] mea = '0;
   bit          m_user = 0, m_reloc = 0, m_zone = 0, m_xok = 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit op_ok(input logic [31:0] w);
      return (w[31:26] == 6'd31) && (w[10:1] == 10'd86);
   endfunction

   function automatic logic [31:0] mkea(input logic [20:0] tg, input logic [5:0] ix, input logic [4:0] off);
      return {tg, ix, off};
   endfunction

   function automatic logic [31:0] mkins(input logic [4:0] raf, input logic [4:0] rbf,
                                         input logic [9:0] xo, input bit rsvd);
      return {6'd31, rsvd ? 5'h1F : 5'h00, raf, rbf, xo, rsvd};
   endfunction

   function automatic bit m_hit();
      return c_val[mea[10:5]] && (c_tag[mea[10:5]] == mea[31:11]);
   endfunction

   function automatic bit m_ftlb();
      return m_reloc && !m_xok;
   endfunction

   function automatic bit m_fdst();
      return !m_ftlb() && m_user && m_reloc && m_zone;
   endfunction

   // model update, array update, watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         errors++;
         $display("FAIL watchdog: run did not finish actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
      if (mw_valid && mw_ready) wq.push_back({mw_addr, mw_data});
      if (done) n_done++;
      if (fault_dtlb) saw_tlb = 1;
      if (fault_dstor) saw_dst = 1;
      if (dbg_valid && dbg_kind == 2'b10) saw_store = 1;
      if (busy) saw_busy = 1;
      if (!rst_n) begin
         ms <= 0;
      end else begin
         case (ms)
            0: if (req_valid && op_ok(req_instr)) begin
                  ms      <= 1;
                  mea     <= ((req_instr[20:16] == 5'd0) ? 32'd0 : ra_val) + rb_val;
                  m_user  <= mode_user;
                  m_reloc <= reloc_en;
                  m_zone  <= zone_no_access;
                  m_xok   <= tlb_hit;
               end
            1: begin
                  mbeat <= 0;
                  if (m_ftlb() || m_fdst() || !m_hit()) ms <= 0;
                  else if (c_dty[mea[10:5]]) ms <= 2;
                  else ms <= 3;
               end
            2: if (mw_ready) begin
                  if (mbeat == 7) ms <= 3;
                  mbeat <= mbeat + 1;
               end
            default: ms <= 0;
         endcase
      end
      if (arr_inv) begin
         c_val[arr_idx] <= 1'b0;
         c_dty[arr_idx] <= 1'b0;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit look, e_done, e_ftlb, e_fdst;
         logic [31:0] e_addr;
         look   = (ms == 1);
         e_ftlb = look && m_ftlb();
         e_fdst = look && m_fdst();
         e_done = (look && (m_ftlb() || m_fdst() || !m_hit())) || (ms == 3);
         e_addr = {mea[31:5], 5'd0} + 32'(mbeat * 4);
         chk(busy == (ms != 0), "R10 busy", busy, ms != 0);
         chk(done == e_done, "R11 done", done, e_done);
         chk(fault_dtlb == e_ftlb, "R7 fault_dtlb", fault_dtlb, e_ftlb);
         chk(fault_dstor == e_fdst, "R8 fault_dstor", fault_dstor, e_fdst);
         chk(dbg_valid == look, "R9 dbg_valid", dbg_valid, look);
         chk(dbg_kind == (look ? 2'b10 : 2'b00), "R9 dbg_kind", dbg_kind, look ? 2'b10 : 2'b00);
         if (look) chk(dbg_ea == mea, "R1 dbg_ea", dbg_ea, mea);
         chk(mw_valid == (ms == 2), "R3 mw_valid", mw_valid, ms == 2);
         chk(arr_inv == (ms == 3), "R4 arr_inv", arr_inv, ms == 3);
         if (ms == 2) begin
            chk(mw_addr == e_addr, "R3 mw_addr", mw_addr, e_addr);
            chk(mw_data == c_dat[mea[10:5]][mbeat], "R3 mw_data", mw_data, c_dat[mea[10:5]][mbeat]);
            chk(mw_last == (mbeat == 7), "R3 mw_last", mw_last, mbeat == 7);
         end
      end
   end

   // ready pattern, driven just after the falling edge
   always @(negedge clk) begin
      #1;
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mw_ready = rdy_rand ? lfsr[0] : 1'b1;
   end

   task automatic set_line(input int ix, input logic [20:0] tg, input bit v, input bit d);
      c_tag[ix] = tg;
      c_val[ix] = v;
      c_dty[ix] = d;
      for (int w = 0; w < 8; w++) c_dat[ix][w] = 32'hD000_0000 | (ix << 8) | (w * 17);
   endtask

   task automatic launch(input logic [31:0] ins, input logic [31:0] rav, input logic [31:0] rbv,
                         input bit u, input bit rl, input bit zn, input bit th, input bit inh);
      @(negedge clk); #1;
      wq.delete();
      n_done = 0; saw_tlb = 0; saw_dst = 0; saw_store = 0; saw_busy = 0;
      req_instr = ins; ra_val = rav; rb_val = rbv;
      mode_user = u; reloc_en = rl; zone_no_access = zn; tlb_hit = th; attr_inhibit = inh;
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic settle();
      for (int i = 0; i < 200; i++) begin
         if (ms == 0 && !busy) break;
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
   endtask

   task automatic run_op(input logic [31:0] ins, input logic [31:0] rav, input logic [31:0] rbv,
                         input bit u, input bit rl, input bit zn, input bit th, input bit inh);
      launch(ins, rav, rbv, u, rl, zn, th, inh);
      settle();
   endtask

   task automatic check_wb(input string tag, input int ix, input logic [20:0] tg);
      chk(wq.size() == 8, {tag, " beat count"}, wq.size(), 8);
      for (int k = 0; k < 8 && k < wq.size(); k++) begin
         logic [31:0] ea_k, da_k;
         ea_k = mkea(tg, ix[5:0], 5'd0) + 32'(k * 4);
         da_k = 32'hD000_0000 | (ix << 8) | (k * 17);
         chk(wq[k] == {ea_k, da_k}, {tag, " beat content"}, wq[k], {ea_k, da_k});
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) set_line(i, 21'h1FFFFF, 0, 0);
      set_line(5,  21'h12345, 1, 1);
      set_line(9,  21'h0ABCD, 1, 0);
      set_line(12, 21'h00777, 1, 1);
      set_line(20, 21'h00C0F, 1, 1);
      set_line(21, 21'h00C10, 1, 1);
      set_line(22, 21'h00C11, 1, 1);
      set_line(30, 21'h01234, 1, 0);
      set_line(31, 21'h01235, 1, 0);
      set_line(40, 21'h02222, 1, 1);
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // reset state
      chk(busy == 0, "R10 reset busy", busy, 0);
      chk(done == 0, "R11 reset done", done, 0);
      chk(mw_valid == 0 && arr_inv == 0, "R3 reset write idle", {mw_valid, arr_inv}, 0);

      // R3: dirty hit, A field non-zero, stalled port
      rdy_rand = 1;
      run_op(mkins(5'd3, 5'd4, 10'd86, 0), mkea(21'h12345, 6'd5, 5'h14) - 32'h100, 32'h100, 0, 0, 0, 1, 0);
      check_wb("R3 dirty hit", 5, 21'h12345);
      chk(c_val[5] == 0, "R3 line invalidated", c_val[5], 0);
      chk(n_done == 1, "R11 one done per op", n_done, 1);
      chk(saw_store == 1, "R9 store report", saw_store, 1);

      // R1 + R4: A field zero ignores ra_val, clean hit
      rdy_rand = 0;
      run_op(mkins(5'd0, 5'd7, 10'd86, 0), 32'hFFFF_0000, mkea(21'h0ABCD, 6'd9, 5'h04), 0, 0, 0, 1, 0);
      chk(wq.size() == 0, "R4 clean hit no writes", wq.size(), 0);
      chk(c_val[9] == 0, "R4 clean line invalidated", c_val[9], 0);
      chk(n_done == 1, "R1 op completed", n_done, 1);

      // R5: inhibited attribute still writes back
      rdy_rand = 1;
      run_op(mkins(5'd2, 5'd1, 10'd86, 0), 32'd0, mkea(21'h00C0F, 6'd20, 5'h1C), 0, 0, 0, 1, 1);
      check_wb("R5 inhibited", 20, 21'h00C0F);
      chk(c_val[20] == 0, "R5 line invalidated", c_val[20], 0);

      // R6: miss on a dirty line with another tag
      run_op(mkins(5'd1, 5'd2, 10'd86, 0), mkea(21'h00778, 6'd12, 5'h00), 32'd8, 0, 0, 0, 1, 0);
      chk(wq.size() == 0, "R6 miss no writes", wq.size(), 0);
      chk(c_val[12] == 1 && c_dty[12] == 1, "R6 line untouched", {c_val[12], c_dty[12]}, 2'b11);
      chk(n_done == 1 && !saw_tlb && !saw_dst, "R6 quiet completion", {n_done[1:0], saw_tlb, saw_dst}, 4'b0100);

      // R7: translation miss (zone flag also set, TLB fault wins)
      run_op(mkins(5'd1, 5'd2, 10'd86, 0), 32'd0, mkea(21'h00C10, 6'd21, 5'h00), 1, 1, 1, 0, 0);
      chk(saw_tlb == 1 && saw_dst == 0, "R7 tlb fault only", {saw_tlb, saw_dst}, 2'b10);
      chk(wq.size() == 0 && c_val[21] == 1, "R7 no flush", {wq.size(), c_val[21]}, 1);

      // R8: user-mode zone fault
      run_op(mkins(5'd1, 5'd2, 10'd86, 0), 32'd0, mkea(21'h00C11, 6'd22, 5'h00), 1, 1, 1, 1, 0);
      chk(saw_dst == 1 && saw_tlb == 0, "R8 zone fault", {saw_tlb, saw_dst}, 2'b01);
      chk(wq.size() == 0 && c_val[22] == 1, "R8 no flush", {wq.size(), c_val[22]}, 1);

      // R8: supervisor mode ignores zone flag
      run_op(mkins(5'd1, 5'd2, 10'd86, 0), 32'd0, mkea(21'h00C11, 6'd22, 5'h00), 0, 1, 1, 1, 0);
      chk(saw_dst == 0 && c_val[22] == 0, "R8 supervisor flush", {saw_dst, c_val[22]}, 2'b00);
      check_wb("R8 supervisor", 22, 21'h00C11);

      // R2: wrong extended opcode is ignored
      run_op(mkins(5'd0, 5'd2, 10'd54, 0), 32'd0, mkea(21'h01234, 6'd30, 5'h00), 0, 0, 0, 1, 0);
      chk(saw_busy == 0 && n_done == 0, "R2 other opcode ignored", {saw_busy, n_done[0]}, 0);
      chk(c_val[30] == 1, "R2 line kept", c_val[30], 1);

      // R2: reserved bits set still flush
      run_op(mkins(5'd0, 5'd2, 10'd86, 1), 32'd0, mkea(21'h01234, 6'd30, 5'h00), 0, 0, 0, 1, 0);
      chk(c_val[30] == 0 && n_done == 1, "R2 reserved bits accepted", {c_val[30], n_done[0]}, 2'b01);

      // R10: request held during write-back is ignored
      rdy_rand = 1;
      launch(mkins(5'd0, 5'd2, 10'd86, 0), 32'd0, mkea(21'h02222, 6'd40, 5'h08), 0, 0, 0, 1, 0);
      @(negedge clk); #1;
      rb_val    = mkea(21'h01235, 6'd31, 5'h00);
      req_valid = 1'b1;
      repeat (4) @(negedge clk);
      #1 req_valid = 1'b0;
      settle();
      check_wb("R10 first op", 40, 21'h02222);
      chk(c_val[31] == 1, "R10 busy request ignored", c_val[31], 1);
      chk(n_done == 1, "R11 single done", n_done, 1);

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule